// File: doc/BRIEF.md
# Read/Write Latency Register Set with Fine Read Vernier

This block keeps the latency settings of one memory device. Four coarse latencies, counted in whole bit intervals, cover page read, page write, bank read and bank write. A fine read vernier adds fractional bit steps on top of the read latencies. The controller sends a stream of single-cycle commands. A command can step the fine vernier up or down, or it can load one coarse latency directly.

When the fine vernier steps past a full bit interval, the excess carries into both coarse read latencies. When it steps below zero, a borrow is taken from them. The read side therefore acts as one continuous delay counter, and that delay never moves against the direction of the step. For each read type the block drives the total launch delay, in fine steps, to the data path. The analog delay element that turns the fine code into time lies outside this block.

Top module: `rd_lat_vernier`

## Requirements
- R1: When reset is released, page read and bank read latency equal RD_MIN_LAT (default 4), page write and bank write latency equal WR_MIN_LAT (default 2), and the fine code is 0.
- R2: A valid command with op code 1 (fine increment) and a fine code below FINE_STEPS (default 16) raises the fine code by one and leaves all coarse latencies as they were. The fine code always stays in the range 0 to FINE_STEPS.
- R3: A valid command with op code 2 (fine decrement) and a fine code above 0 lowers the fine code by one and leaves all coarse latencies as they were.
- R4: A fine increment at fine code FINE_STEPS raises both read latencies by one and clears the fine code to 0.
- R5: A fine decrement at fine code 0 lowers both read latencies by one and sets the fine code to FINE_STEPS.
- R6: A carrying increment when either read latency is at 2^COARSE_W-1 (default 31) changes nothing. A borrowing decrement when either read latency is at RD_MIN_LAT changes nothing.
- R7: A valid command with op code 3 loads cmd_data_i into the field picked by cmd_sel_i (0 page read, 1 page write, 2 bank read, 3 bank write). All other fields and the fine code stay as they were.
- R8: A load with a value below that field's minimum (RD_MIN_LAT for read fields, WR_MIN_LAT for write fields) is ignored.
- R9: Each read delay output equals its read latency times FINE_STEPS plus the fine code. It shows a command's effect at the first clock edge after the command. It never decreases on an increment and never increases on a decrement.
- R10: Fine increments and decrements never change the two write latencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 none, 1 fine increment, 2 fine decrement, 3 load latency |
| cmd_sel_i | input | 2 | Field to load: 0 page read, 1 page write, 2 bank read, 3 bank write |
| cmd_data_i | input | COARSE_W | Latency value to load |
| page_rd_lat_o | output | COARSE_W | Page read coarse latency |
| page_wr_lat_o | output | COARSE_W | Page write coarse latency |
| bank_rd_lat_o | output | COARSE_W | Bank read coarse latency |
| bank_wr_lat_o | output | COARSE_W | Bank write coarse latency |
| fine_o | output | FINE_W | Fine read vernier code |
| page_rd_dly_o | output | DLY_W | Page read launch delay in fine steps |
| bank_rd_dly_o | output | DLY_W | Bank read launch delay in fine steps |

## Verification
The assertions take for granted three things about the inputs. Only one operation arrives per cycle. The op code is stable while cmd_valid_i is high. Reset is held for at least one clock edge. The bench drives every command for one full cycle on the falling edge and then drops cmd_valid_i, so no two operations ever overlap. It walks the fine code through both carry points and both saturation limits, and it loads only values that fit in COARSE_W bits, so every field is checked against its own minimum.

// File: rtl/lat_vernier_pkg.sv
package lat_vernier_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_FINE_INC = 2'd1,
    OP_FINE_DEC = 2'd2,
    OP_LOAD     = 2'd3
  } vern_op_e;

  localparam int unsigned NUM_FLD     = 4;
  localparam int unsigned FLD_PAGE_RD = 0;
  localparam int unsigned FLD_PAGE_WR = 1;
  localparam int unsigned FLD_BANK_RD = 2;
  localparam int unsigned FLD_BANK_WR = 3;
  localparam logic [NUM_FLD-1:0] RD_MASK = 4'b0101;
endpackage

// File: rtl/lat_fine_ctr.sv
module lat_fine_ctr #(
  parameter int unsigned FINE_STEPS = 16,
  parameter int unsigned FINE_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              blk_up_i,
  input  logic              blk_dn_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              carry_up_o,
  output logic              carry_dn_o
);
  localparam logic [FINE_W-1:0] Full = FINE_W'(FINE_STEPS);

  logic [FINE_W-1:0] fine_q, fine_d;

  always_comb begin
    fine_d     = fine_q;
    carry_up_o = 1'b0;
    carry_dn_o = 1'b0;
    if (inc_i) begin
      if (fine_q == Full) begin
        if (!blk_up_i) begin
          fine_d     = '0;
          carry_up_o = 1'b1;
        end
      end else begin
        fine_d = fine_q + 1'b1;
      end
    end else if (dec_i) begin
      if (fine_q == '0) begin
        if (!blk_dn_i) begin
          fine_d     = Full;
          carry_dn_o = 1'b1;
        end
      end else begin
        fine_d = fine_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fine_q <= '0;
    else         fine_q <= fine_d;
  end

  assign fine_o = fine_q;

  // R2
  fine_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_q <= Full);
  // R4
  fine_wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && fine_q == Full && !blk_up_i) |=> (fine_q == '0));
  // R5
  fine_wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && fine_q == '0 && !blk_dn_i) |=> (fine_q == Full));
  // R6
  fine_hold_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && fine_q == Full && blk_up_i) |=> (fine_q == Full));
endmodule

// File: rtl/lat_coarse_reg.sv
module lat_coarse_reg #(
  parameter int unsigned W       = 5,
  parameter int unsigned MIN_LAT = 2,
  parameter int unsigned MAX_LAT = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         up_i,
  input  logic         dn_i,
  output logic [W-1:0] lat_o,
  output logic         at_min_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MinV = W'(MIN_LAT);
  localparam logic [W-1:0] MaxV = W'(MAX_LAT);

  logic [W-1:0] lat_q;
  logic         wr_ok;

  assign wr_ok = wr_en_i && (wr_data_i >= MinV) && (wr_data_i <= MaxV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lat_q <= MinV;
    else if (wr_ok)                 lat_q <= wr_data_i;
    else if (up_i && lat_q != MaxV) lat_q <= lat_q + 1'b1;
    else if (dn_i && lat_q != MinV) lat_q <= lat_q - 1'b1;
  end

  assign lat_o    = lat_q;
  assign at_min_o = (lat_q == MinV);
  assign at_max_o = (lat_q == MaxV);

  // R8
  lat_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q >= MinV) && (lat_q <= MaxV));
  // R8
  low_load_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i < MinV && !up_i && !dn_i) |=> $stable(lat_q));
endmodule

// File: rtl/lat_delay_calc.sv
module lat_delay_calc #(
  parameter int unsigned CW    = 5,
  parameter int unsigned FW    = 5,
  parameter int unsigned STEPS = 16,
  parameter int unsigned DW    = 10
) (
  input  logic [CW-1:0] coarse_i,
  input  logic [FW-1:0] fine_i,
  output logic [DW-1:0] dly_o
);
  assign dly_o = DW'(coarse_i) * DW'(STEPS) + DW'(fine_i);
endmodule

// File: rtl/rd_lat_vernier.sv
module rd_lat_vernier
  import lat_vernier_pkg::*;
#(
  parameter int unsigned COARSE_W   = 5,
  parameter int unsigned FINE_STEPS = 16,
  parameter int unsigned RD_MIN_LAT = 4,
  parameter int unsigned WR_MIN_LAT = 2,
  localparam int unsigned FINE_W    = $clog2(FINE_STEPS + 1),
  localparam int unsigned DLY_W     = $clog2((2**COARSE_W - 1) * FINE_STEPS + FINE_STEPS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [1:0]          cmd_sel_i,
  input  logic [COARSE_W-1:0] cmd_data_i,
  output logic [COARSE_W-1:0] page_rd_lat_o,
  output logic [COARSE_W-1:0] page_wr_lat_o,
  output logic [COARSE_W-1:0] bank_rd_lat_o,
  output logic [COARSE_W-1:0] bank_wr_lat_o,
  output logic [FINE_W-1:0]   fine_o,
  output logic [DLY_W-1:0]    page_rd_dly_o,
  output logic [DLY_W-1:0]    bank_rd_dly_o
);
  localparam int unsigned MaxLat = 2**COARSE_W - 1;

  vern_op_e            op;
  logic                inc, dec, load;
  logic                carry_up, carry_dn, blk_up, blk_dn;
  logic [COARSE_W-1:0] lat_q [NUM_FLD];
  logic [NUM_FLD-1:0]  at_min, at_max;
  logic [FINE_W-1:0]   fine_q;
  logic [DLY_W-1:0]    dly [2];

  assign op   = vern_op_e'(cmd_op_i);
  assign inc  = cmd_valid_i && (op == OP_FINE_INC);
  assign dec  = cmd_valid_i && (op == OP_FINE_DEC);
  assign load = cmd_valid_i && (op == OP_LOAD);

  // a carry must move both read fields, so either limit blocks it
  assign blk_up = |(at_max & RD_MASK);
  assign blk_dn = |(at_min & RD_MASK);

  lat_fine_ctr #(
    .FINE_STEPS (FINE_STEPS),
    .FINE_W     (FINE_W)
  ) u_fine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .dec_i      (dec),
    .blk_up_i   (blk_up),
    .blk_dn_i   (blk_dn),
    .fine_o     (fine_q),
    .carry_up_o (carry_up),
    .carry_dn_o (carry_dn)
  );

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    localparam bit IsRd = RD_MASK[f];
    lat_coarse_reg #(
      .W       (COARSE_W),
      .MIN_LAT (IsRd ? RD_MIN_LAT : WR_MIN_LAT),
      .MAX_LAT (MaxLat)
    ) u_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (load && (cmd_sel_i == 2'(f))),
      .wr_data_i (cmd_data_i),
      .up_i      (IsRd ? carry_up : 1'b0),
      .dn_i      (IsRd ? carry_dn : 1'b0),
      .lat_o     (lat_q[f]),
      .at_min_o  (at_min[f]),
      .at_max_o  (at_max[f])
    );
  end

  for (genvar r = 0; r < 2; r++) begin : g_dly
    lat_delay_calc #(
      .CW    (COARSE_W),
      .FW    (FINE_W),
      .STEPS (FINE_STEPS),
      .DW    (DLY_W)
    ) u_dly (
      .coarse_i (lat_q[r*2]),
      .fine_i   (fine_q),
      .dly_o    (dly[r])
    );
  end

  assign page_rd_lat_o = lat_q[FLD_PAGE_RD];
  assign page_wr_lat_o = lat_q[FLD_PAGE_WR];
  assign bank_rd_lat_o = lat_q[FLD_BANK_RD];
  assign bank_wr_lat_o = lat_q[FLD_BANK_WR];
  assign fine_o        = fine_q;
  assign page_rd_dly_o = dly[0];
  assign bank_rd_dly_o = dly[1];

  // R9
  dly_up_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc |=> (page_rd_dly_o >= $past(page_rd_dly_o)) && (bank_rd_dly_o >= $past(bank_rd_dly_o)));
  // R9
  dly_dn_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec |=> (page_rd_dly_o <= $past(page_rd_dly_o)) && (bank_rd_dly_o <= $past(bank_rd_dly_o)));
  // R10
  wr_lat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc || dec) |=> $stable(page_wr_lat_o) && $stable(bank_wr_lat_o));
  // R7
  load_keeps_fine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> $stable(fine_o));
endmodule

// File: tb/test_rd_lat_vernier.sv
module test_rd_lat_vernier;
  localparam int CW = 5;
  localparam int STEPS = 16;
  localparam int RMIN = 4;
  localparam int WMIN = 2;
  localparam int FW = $clog2(STEPS + 1);
  localparam int DW = $clog2((2**CW - 1) * STEPS + STEPS + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [1:0]    cmd_sel = 2'd0;
  logic [CW-1:0] cmd_data = '0;
  logic [CW-1:0] prd, pwr, brd, bwr;
  logic [FW-1:0] fine;
  logic [DW-1:0] pdly, bdly;

  int checks = 0;
  int errors = 0;
  int e_lat [4];
  int e_fine;

  always #10 clk = ~clk;

  rd_lat_vernier i_rd_lat_vernier (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .cmd_valid_i   (cmd_valid),
    .cmd_op_i      (cmd_op),
    .cmd_sel_i     (cmd_sel),
    .cmd_data_i    (cmd_data),
    .page_rd_lat_o (prd),
    .page_wr_lat_o (pwr),
    .bank_rd_lat_o (brd),
    .bank_wr_lat_o (bwr),
    .fine_o        (fine),
    .page_rd_dly_o (pdly),
    .bank_rd_dly_o (bdly)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "page_rd", int'(prd), e_lat[0]);
    chk(tag, "page_wr", int'(pwr), e_lat[1]);
    chk(tag, "bank_rd", int'(brd), e_lat[2]);
    chk(tag, "bank_wr", int'(bwr), e_lat[3]);
    chk(tag, "fine", int'(fine), e_fine);
    chk("R9", "page_dly", int'(pdly), e_lat[0] * STEPS + e_fine);
    chk("R9", "bank_dly", int'(bdly), e_lat[2] * STEPS + e_fine);
  endtask

  // expected-state update from the requirement text
  task automatic model(input int op, input int sel, input int data);
    if (op == 1) begin
      if (e_fine < STEPS) e_fine++;
      else if (e_lat[0] < 2**CW - 1 && e_lat[2] < 2**CW - 1) begin
        e_fine = 0; e_lat[0]++; e_lat[2]++;
      end
    end else if (op == 2) begin
      if (e_fine > 0) e_fine--;
      else if (e_lat[0] > RMIN && e_lat[2] > RMIN) begin
        e_fine = STEPS; e_lat[0]--; e_lat[2]--;
      end
    end else if (op == 3) begin
      if (data >= (((sel % 2) == 0) ? RMIN : WMIN)) e_lat[sel] = data;
    end
  endtask

  task automatic cmd(input int op, input int sel, input int data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_sel   = 2'(sel);
    cmd_data  = CW'(data);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    model(op, sel, data);
  endtask

  task automatic t_reset();
    e_lat[0] = RMIN; e_lat[1] = WMIN; e_lat[2] = RMIN; e_lat[3] = WMIN; e_fine = 0;
    chk_all("R1");
  endtask

  task automatic t_fine_steps();
    for (int i = 0; i < 3; i++) cmd(1, 0, 0);
    chk_all("R2");
    cmd(2, 0, 0);
    chk_all("R3");
  endtask

  task automatic t_overflow();
    while (e_fine < STEPS) cmd(1, 0, 0);
    chk_all("R2");
    chk("R9", "page_dly_top", int'(pdly), 80);
    cmd(1, 0, 0);
    chk_all("R4");
    chk("R4", "page_rd_carry", int'(prd), RMIN + 1);
    chk("R10", "page_wr_after_carry", int'(pwr), WMIN);
    chk("R9", "page_dly_after_carry", int'(pdly), 80);
  endtask

  task automatic t_underflow();
    cmd(1, 0, 0);
    cmd(2, 0, 0);
    cmd(2, 0, 0);
    chk_all("R5");
    chk("R5", "fine_full", int'(fine), STEPS);
    chk("R5", "bank_rd_borrow", int'(brd), RMIN);
  endtask

  task automatic t_sat_low();
    while (e_fine > 0) cmd(2, 0, 0);
    cmd(2, 0, 0);
    chk_all("R6");
    chk("R6", "fine_hold_low", int'(fine), 0);
  endtask

  task automatic t_load();
    cmd(3, 1, 9);
    cmd(3, 3, 3);
    cmd(3, 2, 7);
    chk_all("R7");
    chk("R7", "bank_rd_loaded", int'(brd), 7);
    chk("R7", "page_rd_kept", int'(prd), RMIN);
  endtask

  task automatic t_low_load();
    cmd(3, 0, 2);
    chk("R8", "page_rd_low", int'(prd), RMIN);
    cmd(3, 1, 1);
    chk("R8", "page_wr_low", int'(pwr), 9);
    cmd(3, 3, WMIN);
    chk_all("R8");
  endtask

  task automatic t_sat_high();
    cmd(3, 0, 31);
    while (e_fine < STEPS) cmd(1, 0, 0);
    cmd(1, 0, 0);
    chk_all("R6");
    chk("R6", "page_rd_hold_high", int'(prd), 31);
    chk("R6", "bank_rd_hold_high", int'(brd), 7);
    cmd(2, 0, 0);
    chk_all("R10");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fine_steps();
    t_overflow();
    t_underflow();
    t_sat_low();
    t_load();
    t_low_load();
    t_sat_high();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule